// File: doc/BRIEF.md
# Quadrature Position Counter with Event Interrupts

This block counts the position of a quadrature pulse tachometer from its A and B channels and turns four external or internal conditions into sticky status flags and one interrupt request. The conditions are a latch input edge, a count-stop input edge, a marker (Z) pulse that coincides with the origin input, and the counter matching a programmable compare value. Every external pin is brought into the clock domain through two flip-flops before any edge is taken from it. Counting is done by a small state machine that remembers the last A/B pair. It can count once per cycle or on every edge.

Software reaches the block through a flat register port. Writes take one cycle and reads are combinational from an address. The port gives access to a control word (the four interrupt enables and the multiplier), a configuration word (edge selects, the counter inhibit and the origin mode), the status word, the live count, the latched count and the compare value. A status flag stays set until software writes a zero to its bit. A count-stop event freezes the counter through the inhibit bit, and the counter stays frozen until software clears that bit.

The quadrature state machine has four states named after the synchronised A/B pair (A is the upper bit): `Q00`, `Q10`, `Q11`, `Q01`. Forward transitions are `Q00→Q10`, `Q10→Q11`, `Q11→Q01` and `Q01→Q00`. Reverse transitions are the same four arrows taken backwards. Diagonal transitions (`Q00↔Q11`, `Q10↔Q01`) are illegal. A transition to the same state is idle. The state always follows the new A/B pair, including after an illegal transition.

Top module: `qci_top`

## Requirements
- R1: After reset the count, latched count, compare value, control word and configuration word read zero, and `irq` is low. Because count equals compare (both zero), status bit 3 is set from the first cycle after reset, so writing control bit 3 raises `irq` immediately.
- R2: With control bit 4 = 1 (x4), each legal forward transition adds one to the count and each reverse transition subtracts one. The count is readable no later than four clock cycles after the A/B change.
- R3: With control bit 4 = 0 (x1), the count changes only when A rises. It goes up by one if B is low and down by one if B is high. All other transitions leave it unchanged.
- R4: A transition in which A and B both change between two synchronised samples leaves the count unchanged. Later transitions are decoded from the new A/B pair.
- R5: The count is a CW-bit (24) two's-complement value that wraps silently. Counting down from 0 gives 0xFFFFFF, and counting up from 0xFFFFFF gives 0.
- R6: A latch event is a rising edge of the latch input when configuration bit 0 = 0, or a falling edge when it is 1. On a latch event the current count is copied to the latch register (address 4) and status bit 0 is set. The edge that is not selected has no effect.
- R7: A count-stop event is a rising edge of the stop input when configuration bit 1 = 0, or a falling edge when it is 1. It sets status bit 1 and configuration bit 2 (inhibit). While inhibit is 1 the count does not move. Writing configuration bit 2 = 0 lets counting resume.
- R8: With configuration bit 3 = 0, a rising edge of (Z AND origin) sets status bit 2 and clears the count. With configuration bit 3 = 1, a rising edge of origin alone clears the count, and status bit 2 is not touched.
- R9: Status bit 3 is set in every cycle in which the count equals the compare register (address 5). A set in the same cycle wins over a clearing write.
- R10: A write to the status word (address 2) clears each status bit written as 0 and leaves each bit written as 1 unchanged. Events set status bits whatever the enables are.
- R11: `irq` is the OR of status bits 0..3, each gated by control enable bits 0..3 (latch, stop, Z-origin, compare). It stays high until every enabled set bit has been cleared.
- R12: Register map: 0 control (rw, bits 4:0), 1 configuration (rw, bits 3:0), 2 status (bits 3:0), 3 count (ro), 4 latched count (ro), 5 compare (rw). Other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 1 | Quadrature channel A (asynchronous) |
| b_in | input | 1 | Quadrature channel B (asynchronous) |
| z_in | input | 1 | Marker pulse (asynchronous) |
| org_in | input | 1 | Origin / clear input (asynchronous) |
| latch_in | input | 1 | External latch input (asynchronous) |
| stop_in | input | 1 | External count-stop input (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest situations to reach are the ones where two mechanisms meet: a compare match that is still true while software tries to clear its flag, the inhibit freezing a count that the inputs keep trying to move, and the wrap at the counter's edge. The stimulus reaches the wrap by sweeping far enough in reverse that the count crosses zero, and then sweeping forward past it again, with the count checked after every single transition. It forces a persistent match by loading the compare register with the live count that was just read. It drives the A/B lines during inhibit and checks that the count stays put both before and after software releases the freeze.

// File: rtl/qci_pkg.sv
package qci_pkg;

    localparam int ADDR_W = 3;
    localparam int NUM_EV = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_CFG   = 3'd1,
        REG_STAT  = 3'd2,
        REG_COUNT = 3'd3,
        REG_LATCH = 3'd4,
        REG_CMP   = 3'd5
    } reg_addr_e;

    // control word bits
    localparam int CTL_IE_LATCH = 0;
    localparam int CTL_IE_STOP  = 1;
    localparam int CTL_IE_ZORG  = 2;
    localparam int CTL_IE_CMP   = 3;
    localparam int CTL_X4       = 4;
    localparam int CTL_W        = 5;

    // configuration word bits
    localparam int CFG_LATCH_FALL = 0;
    localparam int CFG_STOP_FALL  = 1;
    localparam int CFG_INHIBIT    = 2;
    localparam int CFG_ORG_MODE   = 3;
    localparam int CFG_W          = 4;

    // event / status indices
    localparam int EV_LATCH = 0;
    localparam int EV_STOP  = 1;
    localparam int EV_ZORG  = 2;
    localparam int EV_CMP   = 3;

    // synchronised input vector positions
    localparam int IN_A     = 0;
    localparam int IN_B     = 1;
    localparam int IN_Z     = 2;
    localparam int IN_ORG   = 3;
    localparam int IN_LATCH = 4;
    localparam int IN_STOP  = 5;
    localparam int NUM_IN   = 6;

    // quadrature state: {A, B}
    typedef enum logic [1:0] {
        Q00 = 2'b00,
        Q01 = 2'b01,
        Q10 = 2'b10,
        Q11 = 2'b11
    } quad_state_e;

endpackage

// File: rtl/qci_sync.sv
module qci_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] level_q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign level = chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level;
    end
endmodule

// File: rtl/qci_quad_fsm.sv
module qci_quad_fsm
    import qci_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    input  logic x4,
    output logic step,
    output logic up
);
    quad_state_e state;
    quad_state_e next_state;

    assign next_state = quad_state_e'({a, b});

    // state register: always follows the sampled pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q00;
        else        state <= next_state;
    end

    // outputs: decode the transition state -> next_state
    always_comb begin
        logic fwd;
        logic rev;
        fwd  = 1'b0;
        rev  = 1'b0;
        unique case (state)
            Q00: begin
                fwd = (next_state == Q10);
                rev = (next_state == Q01);
            end
            Q10: begin
                fwd = (next_state == Q11);
                rev = (next_state == Q00);
            end
            Q11: begin
                fwd = (next_state == Q01);
                rev = (next_state == Q10);
            end
            Q01: begin
                fwd = (next_state == Q00);
                rev = (next_state == Q11);
            end
            default: begin
                fwd = 1'b0;
                rev = 1'b0;
            end
        endcase
        if (x4) begin
            step = fwd | rev;
            up   = fwd;
        end else begin
            // x1: A rising only, direction from B
            step = (state == Q00 && next_state == Q10) ||
                   (state == Q01 && next_state == Q11);
            up   = (state == Q00);
        end
    end
endmodule

// File: rtl/qci_counter.sv
module qci_counter #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          up,
    input  logic          inhibit,
    input  logic          clear,
    input  logic          latch_evt,
    output logic [CW-1:0] count,
    output logic [CW-1:0] latched
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (step && !inhibit) begin
            count <= up ? count + ONE : count - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         latched <= '0;
        else if (latch_evt) latched <= count;
    end
endmodule

// File: rtl/qci_irq_unit.sv
module qci_irq_unit #(
    parameter int NEV = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] set_evt,
    input  logic           clr_wr,
    input  logic [NEV-1:0] clr_data,
    input  logic [NEV-1:0] enable,
    output logic [NEV-1:0] status,
    output logic           irq
);
    genvar g;
    generate
        for (g = 0; g < NEV; g++) begin : g_flag
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      status[g] <= 1'b0;
                else if (set_evt[g])             status[g] <= 1'b1;
                else if (clr_wr && !clr_data[g]) status[g] <= 1'b0;
            end
        end
    endgenerate

    assign irq = |(status & enable);
endmodule

// File: rtl/qci_top.sv
module qci_top
    import qci_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_in,
    input  logic              b_in,
    input  logic              z_in,
    input  logic              org_in,
    input  logic              latch_in,
    input  logic              stop_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CW-1:0]     wdata,
    output logic [CW-1:0]     rdata,
    output logic              irq
);
    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] lvl;
    logic [NUM_IN-1:0] lvl_q;

    logic [CTL_W-1:0]  ctrl;
    logic              latch_fall;
    logic              stop_fall;
    logic              org_mode;
    logic              inhibit;
    logic [CW-1:0]     cmp_val;

    logic              step;
    logic              up;
    logic [CW-1:0]     count;
    logic [CW-1:0]     latched;
    logic [NUM_EV-1:0] status;
    logic [NUM_EV-1:0] ev_set;

    logic              zo_q;
    logic              zo_lvl;
    logic              latch_evt;
    logic              stop_evt;
    logic              zorg_evt;
    logic              org_rise;
    logic              clear;
    logic              cmp_hit;
    logic              wr_ctrl;
    logic              wr_cfg;
    logic              wr_cmp;
    logic              wr_stat;

    assign raw_in = {stop_in, latch_in, org_in, z_in, b_in, a_in};

    qci_sync #(.W(NUM_IN), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(raw_in),
        .level   (lvl),
        .level_q (lvl_q)
    );

    qci_quad_fsm u_quad (
        .clk  (clk),
        .rst_n(rst_n),
        .a    (lvl[IN_A]),
        .b    (lvl[IN_B]),
        .x4   (ctrl[CTL_X4]),
        .step (step),
        .up   (up)
    );

    // event detection
    assign latch_evt = latch_fall ? (lvl_q[IN_LATCH] & ~lvl[IN_LATCH])
                                  : (lvl[IN_LATCH] & ~lvl_q[IN_LATCH]);
    assign stop_evt  = stop_fall  ? (lvl_q[IN_STOP] & ~lvl[IN_STOP])
                                  : (lvl[IN_STOP] & ~lvl_q[IN_STOP]);
    assign zo_lvl    = lvl[IN_Z] & lvl[IN_ORG];
    assign zorg_evt  = ~org_mode & zo_lvl & ~zo_q;
    assign org_rise  = lvl[IN_ORG] & ~lvl_q[IN_ORG];
    assign clear     = zorg_evt | (org_mode & org_rise);
    assign cmp_hit   = (count == cmp_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zo_q <= 1'b0;
        else        zo_q <= zo_lvl;
    end

    // register writes
    assign wr_ctrl = wr_en && (addr == REG_CTRL);
    assign wr_cfg  = wr_en && (addr == REG_CFG);
    assign wr_cmp  = wr_en && (addr == REG_CMP);
    assign wr_stat = wr_en && (addr == REG_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl       <= '0;
            latch_fall <= 1'b0;
            stop_fall  <= 1'b0;
            org_mode   <= 1'b0;
            cmp_val    <= '0;
        end else begin
            if (wr_ctrl) ctrl <= wdata[CTL_W-1:0];
            if (wr_cfg) begin
                latch_fall <= wdata[CFG_LATCH_FALL];
                stop_fall  <= wdata[CFG_STOP_FALL];
                org_mode   <= wdata[CFG_ORG_MODE];
            end
            if (wr_cmp) cmp_val <= wdata;
        end
    end

    // inhibit: hardware set by a stop event wins over software
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       inhibit <= 1'b0;
        else if (stop_evt) inhibit <= 1'b1;
        else if (wr_cfg)   inhibit <= wdata[CFG_INHIBIT];
    end

    qci_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .up       (up),
        .inhibit  (inhibit),
        .clear    (clear),
        .latch_evt(latch_evt),
        .count    (count),
        .latched  (latched)
    );

    always_comb begin
        ev_set           = '0;
        ev_set[EV_LATCH] = latch_evt;
        ev_set[EV_STOP]  = stop_evt;
        ev_set[EV_ZORG]  = zorg_evt;
        ev_set[EV_CMP]   = cmp_hit;
    end

    qci_irq_unit #(.NEV(NUM_EV)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (ev_set),
        .clr_wr  (wr_stat),
        .clr_data(wdata[NUM_EV-1:0]),
        .enable  (ctrl[NUM_EV-1:0]),
        .status  (status),
        .irq     (irq)
    );

    // read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            REG_CTRL:  rdata[CTL_W-1:0] = ctrl;
            REG_CFG: begin
                rdata[CFG_LATCH_FALL] = latch_fall;
                rdata[CFG_STOP_FALL]  = stop_fall;
                rdata[CFG_INHIBIT]    = inhibit;
                rdata[CFG_ORG_MODE]   = org_mode;
            end
            REG_STAT:  rdata[NUM_EV-1:0] = status;
            REG_COUNT: rdata = count;
            REG_LATCH: rdata = latched;
            REG_CMP:   rdata = cmp_val;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/qci_top_chk.sv
module qci_top_chk
    import qci_pkg::*;
#(
    parameter int CW = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic [NUM_EV-1:0] status,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CW-1:0]     count,
    input logic              inhibit,
    input logic              stop_evt,
    input logic              clear,
    input logic              cmp_hit
);
    localparam logic [CW-1:0] ONE = CW'(1);

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (inhibit && status[EV_STOP])) else $error("stop event"); // R7

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inhibit && !clear) |=> $stable(count)) else $error("inhibit hold"); // R7

    AST_CMP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_hit |=> status[EV_CMP]) else $error("compare flag"); // R9

    AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(wr_en && addr == REG_STAT))
        else $error("status dropped"); // R10

    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && (addr == REG_STAT || addr == REG_CTRL)))
        else $error("irq dropped"); // R11

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clear) |-> (count == $past(count) || count == $past(count) + ONE ||
                           count == $past(count) - ONE))
        else $error("count jump"); // R2
endmodule

bind qci_top qci_top_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .status  (status),
    .wr_en   (wr_en),
    .addr    (addr),
    .count   (count),
    .inhibit (inhibit),
    .stop_evt(stop_evt),
    .clear   (clear),
    .cmp_hit (cmp_hit)
);

// File: tb/qci_top_tb.sv
`timescale 1ns/1ps
module qci_top_tb;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_in = 1'b0, b_in = 1'b0, z_in = 1'b0, org_in = 1'b0;
    logic          latch_in = 1'b0, stop_in = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    addr = 3'd0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          irq;

    int total = 0;
    int bad   = 0;
    logic [CW-1:0] exp_cnt = '0;
    int pos = 0;    // index into the forward gray order 00,10,11,01
    logic x4_mode = 1'b0;

    always #5 clk = ~clk;

    qci_top #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .z_in(z_in),
        .org_in(org_in), .latch_in(latch_in), .stop_in(stop_in),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [1:0] ab_of(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    // move by d positions (+1 fwd, -1 rev, 2 illegal) and update the model
    task automatic move(input int d);
        logic [1:0] o, n;
        o = ab_of(pos);
        pos = (pos + d + 4) & 3;
        n = ab_of(pos);
        if (d == 1 || d == -1) begin
            if (x4_mode) exp_cnt = (d == 1) ? exp_cnt + 1 : exp_cnt - 1;
            else if (!o[1] && n[1]) exp_cnt = n[0] ? exp_cnt - 1 : exp_cnt + 1;
        end
        @(negedge clk);
        a_in = n[1]; b_in = n[0];
        settle();
    endtask

    task automatic chk_count(input string req);
        logic [CW-1:0] v;
        rd(3'd3, v);
        chk(req, v, exp_cnt);
    endtask

    task automatic chk_irq(input string req, input logic e);
        @(negedge clk);
        #1 chk(req, {{(CW-1){1'b0}}, irq}, {{(CW-1){1'b0}}, e});
    endtask

    initial begin : watchdog
        #(1_500_000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [CW-1:0] v;
        logic [CW-1:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(3'd3, v); chk("R1 count", v, '0);
        rd(3'd4, v); chk("R1 latch", v, '0);
        rd(3'd5, v); chk("R1 cmp", v, '0);
        rd(3'd0, v); chk("R1 ctrl", v, '0);
        rd(3'd1, v); chk("R1 cfg", v, '0);
        chk_irq("R1 irq idle", 1'b0);
        rd(3'd2, v); chk("R1 cmp flag at reset", v, 24'h8);
        wr(3'd0, 24'h08);
        chk_irq("R1 immediate compare irq", 1'b1);
        wr(3'd5, 24'h800000);
        wr(3'd2, 24'h0);
        rd(3'd2, v); chk("R10 cleared", v, '0);
        chk_irq("R11 irq after clear", 1'b0);
        rd(3'd5, v); chk("R12 cmp readback", v, 24'h800000);
        rd(3'd6, v); chk("R12 unmapped", v, '0);

        // R2 x4 sweep forward, reverse through zero (R5), forward again
        wr(3'd0, 24'h10); x4_mode = 1'b1;
        rd(3'd0, v); chk("R12 ctrl readback", v, 24'h10);
        for (int i = 0; i < 40; i++) begin move(1); chk_count("R2 x4 fwd"); end
        for (int i = 0; i < 60; i++) begin move(-1); chk_count("R5 x4 rev wrap"); end
        chk("R5 down wrap value", exp_cnt, 24'hFFFFEC);
        for (int i = 0; i < 25; i++) begin move(1); chk_count("R5 x4 up wrap"); end
        // R4 illegal diagonal moves
        for (int i = 0; i < 6; i++) begin
            move(2); chk_count("R4 illegal");
            move(1); chk_count("R4 after illegal");
        end

        // R3 x1 sweep
        wr(3'd0, 24'h00); x4_mode = 1'b0;
        for (int i = 0; i < 48; i++) begin move(1); chk_count("R3 x1 fwd"); end
        for (int i = 0; i < 32; i++) begin move(-1); chk_count("R3 x1 rev"); end

        // R6 latch, rising then falling select
        wr(3'd0, 24'h10); x4_mode = 1'b1;
        @(negedge clk); latch_in = 1'b1; settle();
        rd(3'd4, v); chk("R6 latch rising", v, exp_cnt);
        rd(3'd2, v); chk("R6 latch flag", v, 24'h1);
        keep = exp_cnt;
        wr(3'd1, 24'h1); wr(3'd2, 24'h0);
        move(1); move(1);
        @(negedge clk); latch_in = 1'b0; settle();
        rd(3'd4, v); chk("R6 latch falling", v, exp_cnt);
        move(1);
        @(negedge clk); latch_in = 1'b1; settle();
        rd(3'd4, v); chk("R6 rising ignored", v, exp_cnt - 1);
        rd(3'd2, v); chk("R6 flag once", v, 24'h1);
        chk("R6 moved", exp_cnt - keep == 3 ? 24'h1 : 24'h0, 24'h1);
        @(negedge clk); latch_in = 1'b0; settle();
        wr(3'd1, 24'h0); wr(3'd2, 24'h0);

        // R7 stop / inhibit
        @(negedge clk); stop_in = 1'b1; settle();
        rd(3'd2, v); chk("R7 stop flag", v, 24'h2);
        rd(3'd1, v); chk("R7 inhibit set", v, 24'h4);
        keep = exp_cnt;
        move(1); move(1);
        exp_cnt = keep;
        chk_count("R7 frozen");
        wr(3'd1, 24'h0);
        move(1); chk_count("R7 resumed");
        @(negedge clk); stop_in = 1'b0; settle();
        rd(3'd1, v); chk("R7 falling not selected", v, 24'h0);
        wr(3'd2, 24'h0);

        // R8 Z with origin, mode 0
        @(negedge clk); z_in = 1'b1; settle();
        chk_count("R8 Z alone");
        @(negedge clk); org_in = 1'b1; settle();
        exp_cnt = '0;
        chk_count("R8 zorg clear");
        rd(3'd2, v); chk("R8 zorg flag", v, 24'h4);
        @(negedge clk); z_in = 1'b0; org_in = 1'b0; settle();
        wr(3'd2, 24'h0);
        // R8 mode 1
        wr(3'd1, 24'h8);
        move(1); move(1); move(1);
        chk_count("R8 mode1 pre");
        @(negedge clk); z_in = 1'b1; org_in = 1'b1; settle();
        exp_cnt = '0;
        chk_count("R8 mode1 origin clear");
        rd(3'd2, v); chk("R8 mode1 no flag", v, 24'h0);
        @(negedge clk); z_in = 1'b0; org_in = 1'b0; settle();
        wr(3'd1, 24'h0);

        // R10 masked clear, R11 irq hold
        @(negedge clk); latch_in = 1'b1; stop_in = 1'b1; settle();
        @(negedge clk); z_in = 1'b1; org_in = 1'b1; settle();
        exp_cnt = '0;
        rd(3'd2, v); chk("R10 three flags", v, 24'h7);
        wr(3'd2, 24'hB);
        rd(3'd2, v); chk("R10 masked clear", v, 24'h3);
        wr(3'd0, 24'h13);
        chk_irq("R11 two sources", 1'b1);
        wr(3'd2, 24'hE);
        chk_irq("R11 one left", 1'b1);
        wr(3'd2, 24'h0);
        chk_irq("R11 all clear", 1'b0);
        @(negedge clk); latch_in = 1'b0; stop_in = 1'b0; z_in = 1'b0; org_in = 1'b0;
        settle();
        wr(3'd1, 24'h0);

        // R9 set wins over clear while equal
        move(1); move(1);
        rd(3'd3, v);
        wr(3'd5, v);
        wr(3'd2, 24'h0);
        rd(3'd2, v); chk("R9 set wins", v, 24'h8);
        wr(3'd5, 24'h800000);
        wr(3'd2, 24'h0);
        rd(3'd2, v); chk("R9 cleared after mismatch", v, 24'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule